// File: doc/BRIEF.md
# DDR SDRAM Command Sequencer

This block is the command-issue front end of a memory controller for a four-bank double-data-rate SDRAM with an 8-bit data width. It takes one read or write request at a time, carrying a bank, a 13-bit row, an 11-bit column and an auto-precharge choice. It keeps a record of the open row in every bank, and it drives the chip-select, row-strobe, column-strobe, write-enable, bank and address pins to activate rows, close them, and issue the column command. Address bit 10 selects between a one-bank and an all-bank precharge, and on a column command it requests auto-precharge.

A down-counter loaded with the refresh interval in clock cycles raises a refresh request. A pending refresh wins over new requests. The sequencer closes every open bank with a single all-bank precharge, issues the auto-refresh, and then holds off for the refresh recovery time. All command spacing (precharge time, activate-to-column time, refresh recovery, burst length) comes from parameters counted in controller clocks. When no command is issued, chip select stays high.

Top module: `ddr_cmd_seq`

## Requirements
- R1: Without a command, cs_n is high. Commands use the encodings {cs_n,ras_n,cas_n,we_n}: activate 0011, read 0101, write 0100, precharge 0010, auto-refresh 0001.
- R2: A request to a closed bank gives an activate, with the row on addr and the bank on ba, in the cycle after acceptance. The column command follows T_RCD cycles after the activate.
- R3: A request to the row already open in its bank gives the column command in the cycle after acceptance, with no activate.
- R4: A request to a bank with a different open row gives a precharge with addr[10]=0 on that bank in the cycle after acceptance, an activate T_RP cycles later, and the column command T_RCD cycles after that.
- R5: A column command carries col[9:0] on addr[9:0], col[10] on addr[11], the auto-precharge flag on addr[10] and 0 on addr[12]. ba[0] is the low bank bit.
- R6: A column command with auto-precharge leaves its bank closed, so the next request to that bank starts with an activate. After any column command there is no command for BURST_LEN/2 cycles, plus T_RP when auto-precharge was used.
- R7: The refresh timer raises a request every REFI cycles, and req_ready is low while a request is pending. When the block is idle with all banks closed, auto-refresh commands come exactly REFI cycles apart.
- R8: An auto-refresh is issued only with all banks closed. If any bank is open, a precharge with addr[10]=1 comes first, and the refresh follows T_RP cycles later.
- R9: After an auto-refresh, req_ready stays low and no command is issued for T_RFC cycles.
- R10: req_ready is high only when the sequencer is idle with no refresh pending. A request is taken on a rising edge with req_valid and req_ready both high, and req_ready is low while its commands run.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Controller clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Request present |
| req_write | input | 1 | 1 = write, 0 = read |
| req_bank | input | 2 | Target bank |
| req_row | input | 13 | Target row |
| req_col | input | 11 | Burst start column |
| req_autopre | input | 1 | Close the bank after this burst |
| req_ready | output | 1 | Request can be taken this cycle |
| cs_n | output | 1 | Chip select, active low |
| ras_n | output | 1 | Row strobe, active low |
| cas_n | output | 1 | Column strobe, active low |
| we_n | output | 1 | Write enable, active low |
| ba | output | 2 | Bank address |
| addr | output | 13 | Row, column and precharge control |

## Verification
The hardest case to reach is a refresh that arrives while a bank is open, because only then does the all-bank precharge come before the auto-refresh. The bench opens a bank with a request that has no auto-precharge, stops sending requests, and waits for the timer. It checks the precharge with address bit 10 set, the refresh T_RP cycles later, and the recovery window after it. It then lets two refreshes run with all banks closed and measures their spacing against REFI. Before that, a sweep over every bank runs closed, hit, miss and auto-precharge requests, and the bench works out each expected command cycle from its own model of the open rows.

// File: rtl/ddr_cmd_seq.sv
module ddr_cmd_seq #(
  parameter int T_RP      = 3,
  parameter int T_RCD     = 3,
  parameter int T_RFC     = 10,
  parameter int BURST_LEN = 4,
  parameter int CLK_PS    = 8000,
  parameter int REFI      = 7800000 / CLK_PS
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        req_valid,
  input  logic        req_write,
  input  logic [1:0]  req_bank,
  input  logic [12:0] req_row,
  input  logic [10:0] req_col,
  input  logic        req_autopre,
  output logic        req_ready,
  output logic        cs_n,
  output logic        ras_n,
  output logic        cas_n,
  output logic        we_n,
  output logic [1:0]  ba,
  output logic [12:0] addr
);
  localparam int BC = BURST_LEN / 2;
  localparam int CW = $clog2(T_RFC + T_RP + T_RCD + BC + 2);
  localparam int RW = $clog2(REFI + 1);

  typedef enum logic [2:0] {S_IDLE, S_PRE, S_ACT, S_COL, S_PREALL, S_REF, S_WAIT} st_t;

  st_t st, nxt, wnext;
  int wlen;
  logic [CW-1:0] cnt;
  logic [RW-1:0] rcnt;
  logic ref_flag;
  logic [3:0] open;
  logic [12:0] open_row [4];
  logic q_wr, q_ap;
  logic [1:0] q_bank;
  logic [12:0] q_row;
  logic [10:0] q_col;

  assign req_ready = (st == S_IDLE) && !ref_flag;

  always_comb begin
    {cs_n, ras_n, cas_n, we_n} = 4'b1111;
    ba = q_bank;
    addr = '0;
    case (st)
      S_PRE:    {cs_n, ras_n, cas_n, we_n} = 4'b0010;
      S_PREALL: begin {cs_n, ras_n, cas_n, we_n} = 4'b0010; addr[10] = 1'b1; ba = '0; end
      S_ACT:    begin {cs_n, ras_n, cas_n, we_n} = 4'b0011; addr = q_row; end
      S_COL:    begin
        {cs_n, ras_n, cas_n, we_n} = q_wr ? 4'b0100 : 4'b0101;
        addr = {1'b0, q_col[10], q_ap, q_col[9:0]};
      end
      S_REF:    begin {cs_n, ras_n, cas_n, we_n} = 4'b0001; ba = '0; end
      default:  ;
    endcase
  end

  always_comb begin
    wnext = S_IDLE;
    wlen = 1;
    case (st)
      S_PRE:    begin wnext = S_ACT; wlen = T_RP; end
      S_ACT:    begin wnext = S_COL; wlen = T_RCD; end
      S_COL:    begin wnext = S_IDLE; wlen = q_ap ? BC + T_RP : BC; end
      S_PREALL: begin wnext = S_REF; wlen = T_RP; end
      S_REF:    begin wnext = S_IDLE; wlen = T_RFC; end
      default:  ;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rcnt <= RW'(REFI - 1);
      ref_flag <= 1'b0;
    end else begin
      if (st == S_REF) ref_flag <= 1'b0;
      if (rcnt == '0) begin
        rcnt <= RW'(REFI - 1);
        ref_flag <= 1'b1;
      end else rcnt <= rcnt - 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st <= S_IDLE;
      nxt <= S_IDLE;
      cnt <= '0;
      open <= '0;
      for (int i = 0; i < 4; i++) open_row[i] <= '0;
      q_wr <= 1'b0; q_ap <= 1'b0; q_bank <= '0; q_row <= '0; q_col <= '0;
    end else begin
      case (st)
        S_IDLE: begin
          if (ref_flag) st <= (|open) ? S_PREALL : S_REF;
          else if (req_valid) begin
            q_wr <= req_write; q_ap <= req_autopre; q_bank <= req_bank;
            q_row <= req_row; q_col <= req_col;
            if (!open[req_bank]) st <= S_ACT;
            else if (open_row[req_bank] == req_row) st <= S_COL;
            else st <= S_PRE;
          end
        end
        S_WAIT: begin
          if (cnt == '0) st <= nxt;
          else cnt <= cnt - 1'b1;
        end
        default: begin
          if (st == S_PRE) open[q_bank] <= 1'b0;
          if (st == S_PREALL) open <= '0;
          if (st == S_ACT) begin
            open[q_bank] <= 1'b1;
            open_row[q_bank] <= q_row;
          end
          if (st == S_COL && q_ap) open[q_bank] <= 1'b0;
          if (wlen > 1) begin
            st <= S_WAIT;
            nxt <= wnext;
            cnt <= CW'(wlen - 2);
          end else st <= wnext;
        end
      endcase
    end
  end

  logic is_cmd, is_act, is_col, is_pre, is_ref;
  assign is_cmd = !cs_n;
  assign is_act = is_cmd && !ras_n && cas_n && we_n;
  assign is_pre = is_cmd && !ras_n && cas_n && !we_n;
  assign is_col = is_cmd && ras_n && !cas_n;
  assign is_ref = is_cmd && !ras_n && !cas_n && we_n;

  int gap;
  logic [2:0] last;
  logic last_ap;
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      gap <= 1000; last <= 3'd0; last_ap <= 1'b0;
    end else if (is_cmd) begin
      gap <= 1;
      last <= is_act ? 3'd1 : is_col ? 3'd2 : is_pre ? 3'd3 : is_ref ? 3'd4 : 3'd5;
      last_ap <= addr[10];
    end else if (gap < 1000) gap <= gap + 1;
  end

  p_idle_deselect_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (st == S_IDLE || st == S_WAIT) |-> cs_n);
  p_rcd_gap_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (is_col && last == 3'd1) |-> gap >= T_RCD);
  p_rp_gap_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (is_act && last == 3'd3) |-> gap >= T_RP);
  p_burst_gap_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (is_cmd && last == 3'd2) |-> gap >= (last_ap ? BC + T_RP : BC));
  p_ref_closed_r8: assert property (@(posedge clk) disable iff (!rst_n)
    is_ref |-> open == 4'b0000);
  p_act_closed_r2: assert property (@(posedge clk) disable iff (!rst_n)
    is_act |-> !open[ba]);
  p_rfc_gap_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (is_cmd && last == 3'd4) |-> gap >= T_RFC);
endmodule

// File: tb/ddr_cmd_seq_tb.sv
module ddr_cmd_seq_tb;
  localparam int T_RP = 3, T_RCD = 2, T_RFC = 7, BL = 4, REFI = 300;
  localparam int BC = BL / 2;
  localparam int K_NONE = 0, K_ACT = 1, K_RD = 2, K_WR = 3, K_PRE = 4, K_REF = 5, K_BAD = 6;

  logic clk = 1'b0, rst_n = 1'b0;
  logic req_valid = 1'b0, req_write = 1'b0, req_autopre = 1'b0;
  logic [1:0] req_bank = '0;
  logic [12:0] req_row = '0;
  logic [10:0] req_col = '0;
  logic req_ready, cs_n, ras_n, cas_n, we_n;
  logic [1:0] ba;
  logic [12:0] addr;

  ddr_cmd_seq #(.T_RP(T_RP), .T_RCD(T_RCD), .T_RFC(T_RFC), .BURST_LEN(BL), .REFI(REFI)) u_dut (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_write(req_write),
    .req_bank(req_bank), .req_row(req_row), .req_col(req_col), .req_autopre(req_autopre),
    .req_ready(req_ready), .cs_n(cs_n), .ras_n(ras_n), .cas_n(cas_n), .we_n(we_n),
    .ba(ba), .addr(addr));

  always #4 clk = ~clk;

  int total = 0, bad = 0, ncyc = 0;
  int lastcol = -1000;
  logic lastap = 1'b0;
  bit m_open [4];
  int m_row [4];
  bit done = 0;

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  function automatic int kind();
    case ({cs_n, ras_n, cas_n, we_n})
      4'b1111, 4'b1110, 4'b1101, 4'b1100, 4'b1011, 4'b1010, 4'b1001, 4'b1000: return K_NONE;
      4'b0011: return K_ACT;
      4'b0101: return K_RD;
      4'b0100: return K_WR;
      4'b0010: return K_PRE;
      4'b0001: return K_REF;
      default: return K_BAD;
    endcase
  endfunction

  task automatic step();
    @(negedge clk);
    ncyc++;
    if (kind() == K_REF || (kind() == K_PRE && addr[10]))
      for (int i = 0; i < 4; i++) m_open[i] = 0;
  endtask

  task automatic do_req(input bit wr, input int b, input int row, input int col, input bit ap);
    int ek [3];
    int ec [3];
    int n, hit, stray;
    bit seen;
    while (!req_ready) step();
    n = 0;
    if (!m_open[b]) begin
      ek[0] = K_ACT; ec[0] = 0; ek[1] = wr ? K_WR : K_RD; ec[1] = T_RCD; n = 2;
    end else if (m_row[b] == row) begin
      ek[0] = wr ? K_WR : K_RD; ec[0] = 0; n = 1;
    end else begin
      ek[0] = K_PRE; ec[0] = 0; ek[1] = K_ACT; ec[1] = T_RP;
      ek[2] = wr ? K_WR : K_RD; ec[2] = T_RP + T_RCD; n = 3;
    end
    req_valid = 1'b1; req_write = wr; req_bank = 2'(b); req_row = 13'(row);
    req_col = 11'(col); req_autopre = ap;
    step();
    req_valid = 1'b0;
    check(req_ready == 1'b0, "R10 ready low while busy", int'(req_ready), 0);
    check(ncyc - lastcol >= (lastap ? BC + T_RP : BC), "R6 gap after column cmd",
          ncyc - lastcol, lastap ? BC + T_RP : BC);
    hit = 0; stray = 0; seen = 0;
    for (int k = 0; k < 20 && !seen; k++) begin
      if (k > 0) step();
      if (hit < n && ec[hit] == k) begin
        check(kind() == ek[hit], "R1/R2/R3/R4 command kind", kind(), ek[hit]);
        check(ba == 2'(b), "R5 bank address", int'(ba), b);
        if (ek[hit] == K_ACT) check(addr == 13'(row), "R2 row on addr", int'(addr), row);
        if (ek[hit] == K_PRE) check(addr[10] == 1'b0, "R4 single-bank precharge a10", int'(addr[10]), 0);
        if (hit == n - 1) begin
          check(addr == {1'b0, 1'(col >> 10), ap, 10'(col)}, "R5 column addr",
                int'(addr), int'({1'b0, 1'(col >> 10), ap, 10'(col)}));
          lastcol = ncyc; lastap = ap; seen = 1;
        end
        hit++;
      end else if (!cs_n) stray++;
    end
    check(stray == 0 && seen, "R1 deselect between commands", stray, 0);
    m_open[b] = !ap;
    m_row[b] = row;
  endtask

  initial begin
    #(8 * 150000);
    if (!done) begin
      bad++; total++;
      $display("FAIL watchdog actual=%0d expected=%0d", ncyc, 0);
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    int p, r, r2, r3;
    for (int i = 0; i < 4; i++) begin m_open[i] = 0; m_row[i] = 0; end
    repeat (3) step();
    check(cs_n == 1'b1, "R1 reset deselect", int'(cs_n), 1);
    rst_n = 1'b1;
    step();
    check(cs_n == 1'b1 && req_ready == 1'b1, "R10 idle ready after reset", int'(req_ready), 1);

    for (int b = 0; b < 4; b++) begin
      do_req(b[0], b, 5 + b, 11'h400 | (b * 37), 1'b0);
      do_req(!b[0], b, 5 + b, b * 3, 1'b0);
      do_req(1'b0, b, 100 + b, 11'h3ff, b[0]);
      do_req(1'b1, b, 100 + b, 11'h7ff, 1'b1);
      do_req(1'b0, b, 100 + b, 11'h001, 1'b0);
    end
    for (int b = 0; b < 4; b++) do_req(1'b1, 3 - b, 8191, 11'h555, 1'b0);

    p = -1;
    for (int k = 0; k < REFI + 50 && p < 0; k++) begin
      step();
      if (kind() == K_PRE) begin
        p = ncyc;
        check(addr[10] == 1'b1, "R8 all-bank precharge a10", int'(addr[10]), 1);
        check(req_ready == 1'b0, "R7 ready low while refresh pending", int'(req_ready), 0);
      end
    end
    check(p >= 0, "R8 precharge before refresh seen", p, 1);
    r = -1;
    for (int k = 0; k < 20 && r < 0; k++) begin
      step();
      if (kind() == K_REF) r = ncyc;
    end
    check(r - p == T_RP, "R8 refresh after precharge", r - p, T_RP);
    for (int k = 1; k < T_RFC; k++) begin
      step();
      check(req_ready == 1'b0 && cs_n == 1'b1, "R9 refresh recovery hold", int'(req_ready), 0);
    end
    step();
    check(req_ready == 1'b1, "R9 ready after recovery", int'(req_ready), 1);

    r2 = -1; r3 = -1;
    for (int k = 0; k < 3 * REFI && r3 < 0; k++) begin
      step();
      if (kind() == K_REF) begin
        if (r2 < 0) r2 = ncyc; else r3 = ncyc;
      end
    end
    check(r3 - r2 == REFI, "R7 refresh interval", r3 - r2, REFI);

    do_req(1'b0, 2, 77, 11'h012, 1'b0);
    do_req(1'b1, 2, 77, 11'h013, 1'b1);
    do_req(1'b0, 2, 77, 11'h014, 1'b0);

    done = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule